// File: doc/BRIEF.md
# Programmable Pad Cell Bank

This block is a bank of pad cells for a programmable logic fabric. Each cell takes one output function and one output enable from the fabric's logic cells, each chosen by its own routing multiplexer. The output function passes through a polarity inverter on its way to the three-state pad driver. The pad is modelled as three separate signals: the value from outside, the value to drive, and the drive enable. The value seen at the pad is always returned to the fabric. Each cell chooses whether it is returned straight through, through an edge-triggered capture register, or through a level-sensitive latch.

The cells are split into two equal halves. The lower half is group A and the upper half is group B. Each group has its own capture-clock control. That control picks one of two shared clock pins or the group's own fabric-generated clock term, and it can invert the choice so that capture happens on the falling edge. All logic runs on one system clock. A small state machine per group samples the chosen capture clock on that system clock and reports its level and its active edge.

The tracker has three states. `TRK_START` is entered on reset. On the first sample it moves to `TRK_LOW` or `TRK_HIGH` depending on the level it sees, and it reports no edge on that move. `TRK_LOW` moves to `TRK_HIGH` when the level goes high, and that transition is the active edge. `TRK_HIGH` moves to `TRK_LOW` when the level goes low.

Top module: `pio_bank`

## Requirements
- R1: `pad_out[i]` equals `lc_out[cell_out_sel of cell i]` XOR `cell_out_inv[i]` in the same cycle, where the select field of cell i is `cell_out_sel[i*SEL_W +: SEL_W]`.
- R2: `pad_oe[i]` equals `lc_oe[cell_oe_sel of cell i]` in the same cycle. A deasserted enable does not stop the input path from capturing `pad_in[i]`.
- R3: In bypass mode, `fb[i]` equals `pad_in[i]` in the same cycle.
- R4: In register mode (`cell_mode[2i+1:2i]` = 2'b01), `fb[i]` takes the `pad_in[i]` value sampled at the system-clock edge where the group's effective capture clock is first seen high after being seen low. It holds at every other edge.
- R5: In latch mode (2'b10), `fb[i]` takes `pad_in[i]` at each system-clock edge where the effective capture clock is high. It holds while that clock is low.
- R6: The group clock select, 2 bits per group (`grp_clk_sel[1:0]` for A, `[3:2]` for B), picks a source: 2'b00 selects `ext_clk1`, 2'b01 selects `ext_clk2`, and 2'b10 or 2'b11 selects the group's term `arr_clk[g]`.
- R7: When `grp_clk_inv[g]` is 1, the chosen source is inverted, so register capture happens on its falling edge.
- R8: Cells 0 to N_CELLS/2-1 use the group A control (index 0). The remaining cells use group B (index 1). Clock activity in one group never changes the stored value of a cell in the other group.
- R9: While `rst_n` is low, every stored value is 0. The first sample after reset sets the tracker to the current level without reporting an edge, so a clock that is already high at release does not cause a capture.
- R10: Mode encoding: 2'b00 and 2'b11 are both bypass, 2'b01 is register, and 2'b10 is latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| ext_clk1 | input | 1 | Shared clock pin 1 |
| ext_clk2 | input | 1 | Shared clock pin 2 |
| arr_clk | input | 2 | Fabric clock term per group (0 = A, 1 = B) |
| grp_clk_sel | input | 4 | Clock source select, 2 bits per group |
| grp_clk_inv | input | 2 | Clock inversion per group |
| lc_out | input | N_LC | Output functions from logic cells |
| lc_oe | input | N_LC | Output enables from logic cells |
| cell_out_sel | input | N_CELLS*SEL_W | Output function select per cell |
| cell_oe_sel | input | N_CELLS*SEL_W | Output enable select per cell |
| cell_out_inv | input | N_CELLS | Output polarity per cell |
| cell_mode | input | 2*N_CELLS | Input-path mode per cell |
| pad_in | input | N_CELLS | Value seen at each pad |
| pad_out | output | N_CELLS | Value driven to each pad |
| pad_oe | output | N_CELLS | Drive enable of each pad |
| fb | output | N_CELLS | Pad value returned to the fabric |

## Verification
The output path (R1, R2) and bypass mode (R3, R10) are combinational. The bench checks them one nanosecond after it changes the inputs, with no clock edge in between. Register and latch results (R4, R5, R7, R8) appear right after the first system-clock edge that samples the new clock level and pad value. The bench therefore drives these inputs just after an edge, then waits for exactly one edge before checking `fb`. Reset and tracker start-up (R9) are checked at the first and second edges after release. Any source or group switch is set up so that the effective level does not change, and the stored value is made known before the edge under test.

// File: rtl/pio_pkg.sv
package pio_pkg;

    typedef enum logic [1:0] {
        IN_BYPASS     = 2'b00,
        IN_REG        = 2'b01,
        IN_LATCH      = 2'b10,
        IN_BYPASS_ALT = 2'b11
    } in_mode_e;

    typedef enum logic [1:0] {
        TRK_START = 2'b00,
        TRK_LOW   = 2'b01,
        TRK_HIGH  = 2'b10
    } trk_state_e;

    localparam logic [1:0] CSEL_PIN1 = 2'b00;
    localparam logic [1:0] CSEL_PIN2 = 2'b01;

endpackage

// File: rtl/pio_clk_sel.sv
module pio_clk_sel
    import pio_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin1,
    input  logic       pin2,
    input  logic       term,
    input  logic [1:0] sel,
    input  logic       inv,
    output logic       lvl,
    output logic       act_edge
);

    logic       raw;
    trk_state_e st, st_nx;

    always_comb begin
        unique case (sel)
            CSEL_PIN1: raw = pin1;
            CSEL_PIN2: raw = pin2;
            default:   raw = term;
        endcase
    end

    assign lvl = raw ^ inv;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= TRK_START;
        else        st <= st_nx;
    end

    // next state
    always_comb begin
        st_nx = st;
        unique case (st)
            TRK_START: st_nx = lvl ? TRK_HIGH : TRK_LOW;
            TRK_LOW:   if (lvl)  st_nx = TRK_HIGH;
            TRK_HIGH:  if (!lvl) st_nx = TRK_LOW;
            default:   st_nx = TRK_START;
        endcase
    end

    // outputs
    always_comb begin
        unique case (st)
            TRK_LOW: act_edge = lvl;
            default: act_edge = 1'b0;
        endcase
    end

endmodule

// File: rtl/pio_in_stage.sv
module pio_in_stage
    import pio_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pad,
    input  logic [1:0] mode,
    input  logic       lvl,
    input  logic       act_edge,
    output logic       fb
);

    in_mode_e m;
    logic     stored;

    assign m = in_mode_e'(mode);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stored <= 1'b0;
        end else begin
            unique case (m)
                IN_REG:   if (act_edge) stored <= pad;
                IN_LATCH: if (lvl)      stored <= pad;
                default:  stored <= stored;
            endcase
        end
    end

    always_comb begin
        unique case (m)
            IN_REG, IN_LATCH: fb = stored;
            default:          fb = pad;
        endcase
    end

endmodule

// File: rtl/pio_out_stage.sv
module pio_out_stage #(
    parameter int N_LC  = 8,
    parameter int SEL_W = 3
) (
    input  logic [N_LC-1:0]  lc_out,
    input  logic [N_LC-1:0]  lc_oe,
    input  logic [SEL_W-1:0] out_sel,
    input  logic [SEL_W-1:0] oe_sel,
    input  logic             out_inv,
    output logic             pad_out,
    output logic             pad_oe
);

    logic fn_sel;

    always_comb begin
        fn_sel = 1'b0;
        pad_oe = 1'b0;
        for (int k = 0; k < N_LC; k++) begin
            if (out_sel == SEL_W'(k)) fn_sel = lc_out[k];
            if (oe_sel  == SEL_W'(k)) pad_oe = lc_oe[k];
        end
        pad_out = fn_sel ^ out_inv;
    end

endmodule

// File: rtl/pio_bank.sv
module pio_bank
    import pio_pkg::*;
#(
    parameter  int N_CELLS = 4,
    parameter  int N_LC    = 8,
    localparam int SEL_W   = $clog2(N_LC),
    localparam int HALF    = N_CELLS / 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ext_clk1,
    input  logic                     ext_clk2,
    input  logic [1:0]               arr_clk,
    input  logic [3:0]               grp_clk_sel,
    input  logic [1:0]               grp_clk_inv,
    input  logic [N_LC-1:0]          lc_out,
    input  logic [N_LC-1:0]          lc_oe,
    input  logic [N_CELLS*SEL_W-1:0] cell_out_sel,
    input  logic [N_CELLS*SEL_W-1:0] cell_oe_sel,
    input  logic [N_CELLS-1:0]       cell_out_inv,
    input  logic [2*N_CELLS-1:0]     cell_mode,
    input  logic [N_CELLS-1:0]       pad_in,
    output logic [N_CELLS-1:0]       pad_out,
    output logic [N_CELLS-1:0]       pad_oe,
    output logic [N_CELLS-1:0]       fb
);

    logic [1:0] grp_lvl;
    logic [1:0] grp_edge;

    for (genvar g = 0; g < 2; g++) begin : g_grp
        pio_clk_sel u_gclk (
            .clk      (clk),
            .rst_n    (rst_n),
            .pin1     (ext_clk1),
            .pin2     (ext_clk2),
            .term     (arr_clk[g]),
            .sel      (grp_clk_sel[2*g +: 2]),
            .inv      (grp_clk_inv[g]),
            .lvl      (grp_lvl[g]),
            .act_edge (grp_edge[g])
        );
    end

    for (genvar i = 0; i < N_CELLS; i++) begin : g_cell
        localparam int G = (i < HALF) ? 0 : 1;

        pio_out_stage #(.N_LC(N_LC), .SEL_W(SEL_W)) u_out (
            .lc_out  (lc_out),
            .lc_oe   (lc_oe),
            .out_sel (cell_out_sel[i*SEL_W +: SEL_W]),
            .oe_sel  (cell_oe_sel[i*SEL_W +: SEL_W]),
            .out_inv (cell_out_inv[i]),
            .pad_out (pad_out[i]),
            .pad_oe  (pad_oe[i])
        );

        pio_in_stage u_in (
            .clk      (clk),
            .rst_n    (rst_n),
            .pad      (pad_in[i]),
            .mode     (cell_mode[2*i +: 2]),
            .lvl      (grp_lvl[G]),
            .act_edge (grp_edge[G]),
            .fb       (fb[i])
        );
    end

endmodule

// File: rtl/pio_bank_chk.sv
module pio_bank_chk #(
    parameter int N_CELLS = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [2*N_CELLS-1:0] cell_mode,
    input logic [N_CELLS-1:0]   pad_in,
    input logic [N_CELLS-1:0]   fb,
    input logic [1:0]           grp_lvl,
    input logic [1:0]           grp_edge
);

    for (genvar g = 0; g < 2; g++) begin : g_grp
        // R9: an edge needs a low sample before it
        p_edge_after_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
            grp_edge[g] |-> !$past(grp_lvl[g]));
        // R9: no edge on the first sample after release
        p_start_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(rst_n) |-> !grp_edge[g]);
    end

    for (genvar i = 0; i < N_CELLS; i++) begin : g_cell
        localparam int G = (i < N_CELLS / 2) ? 0 : 1;
        logic [1:0] m;
        assign m = cell_mode[2*i +: 2];

        p_reg_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (m == 2'b01 && grp_edge[G]) |=> (m != 2'b01 || fb[i] == $past(pad_in[i])));
        p_reg_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (m == 2'b01 && !grp_edge[G]) |=> (m != 2'b01 || $stable(fb[i])));
        p_latch_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (m == 2'b10 && grp_lvl[G]) |=> (m != 2'b10 || fb[i] == $past(pad_in[i])));
        p_latch_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (m == 2'b10 && !grp_lvl[G]) |=> (m != 2'b10 || $stable(fb[i])));
    end

endmodule

bind pio_bank pio_bank_chk #(.N_CELLS(N_CELLS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cell_mode (cell_mode),
    .pad_in    (pad_in),
    .fb        (fb),
    .grp_lvl   (grp_lvl),
    .grp_edge  (grp_edge)
);

// File: tb/pio_bank_test.sv
`timescale 1ns/1ps
module pio_bank_test;

    localparam int NC = 4;
    localparam int NL = 8;
    localparam int SW = 3;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          ext_clk1, ext_clk2;
    logic [1:0]    arr_clk;
    logic [3:0]    grp_clk_sel;
    logic [1:0]    grp_clk_inv;
    logic [NL-1:0] lc_out, lc_oe;
    logic [NC*SW-1:0] cell_out_sel, cell_oe_sel;
    logic [NC-1:0] cell_out_inv;
    logic [2*NC-1:0] cell_mode;
    logic [NC-1:0] pad_in;
    logic [NC-1:0] pad_out, pad_oe, fb;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    pio_bank #(.N_CELLS(NC), .N_LC(NL)) uut (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic set_mode(input int i, input logic [1:0] m);
        cell_mode[2*i +: 2] = m;
    endtask

    task automatic t_reset();
        rst_n = 0; ext_clk1 = 1; ext_clk2 = 0; arr_clk = 0;
        grp_clk_sel = 4'b0000; grp_clk_inv = 0;
        lc_out = 0; lc_oe = 0; cell_out_sel = 0; cell_oe_sel = 0; cell_out_inv = 0;
        cell_mode = {NC{2'b01}}; pad_in = '1;
        repeat (3) step();
        chk("R9 reset clears storage", fb, 4'b0000);
        rst_n = 1;
        step();
        chk("R9 no capture at release with clock high", fb, 4'b0000);
        step();
        chk("R9 still no capture while high", fb, 4'b0000);
        ext_clk1 = 0; step();
        ext_clk1 = 1; step();
        chk("R4 first rise captures", fb, 4'b1111);
    endtask

    task automatic t_register();
        pad_in[0] = 0; ext_clk1 = 0; step();
        ext_clk1 = 1; step();
        chk("R4 capture 0 on rise", fb[0], 0);
        pad_in[0] = 1; step();
        chk("R4 hold while high", fb[0], 0);
        ext_clk1 = 0; step();
        chk("R4 hold on fall", fb[0], 0);
        ext_clk1 = 1; step();
        chk("R4 capture 1 on rise", fb[0], 1);
    endtask

    task automatic t_latch();
        set_mode(1, 2'b10);
        ext_clk1 = 1; pad_in[1] = 0; step();
        chk("R5 follows 0 while high", fb[1], 0);
        pad_in[1] = 1; step();
        chk("R5 follows 1 while high", fb[1], 1);
        ext_clk1 = 0; step();
        pad_in[1] = 0; step();
        chk("R5 holds while low", fb[1], 1);
        ext_clk1 = 1; step();
        chk("R5 transparent again", fb[1], 0);
        set_mode(1, 2'b01);
    endtask

    task automatic t_bypass();
        set_mode(2, 2'b00);
        pad_in[2] = 0; #1;
        chk("R3 bypass 0", fb[2], 0);
        pad_in[2] = 1; #1;
        chk("R3 bypass 1", fb[2], 1);
        set_mode(2, 2'b11);
        pad_in[2] = 0; #1;
        chk("R10 code 11 is bypass", fb[2], 0);
        set_mode(2, 2'b01);
        step();
    endtask

    task automatic t_output();
        lc_out = 8'b1010_0110;
        lc_oe  = 8'b0000_0100;
        cell_out_sel[0 +: SW] = 3'd1; cell_out_inv[0] = 0; #1;
        chk("R1 route src1", pad_out[0], 1);
        cell_out_inv[0] = 1; #1;
        chk("R1 inverted", pad_out[0], 0);
        cell_out_sel[0 +: SW] = 3'd3; cell_out_inv[0] = 0; #1;
        chk("R1 route src3", pad_out[0], 0);
        cell_out_sel[3*SW +: SW] = 3'd7; #1;
        chk("R1 cell3 src7", pad_out[3], 1);
        cell_oe_sel[0 +: SW] = 3'd2; #1;
        chk("R2 oe src2", pad_oe[0], 1);
        cell_oe_sel[0 +: SW] = 3'd0; #1;
        chk("R2 oe src0", pad_oe[0], 0);
        // fb[0] is 1 here; capture 0 with the drive disabled
        pad_in[0] = 0; ext_clk1 = 0; step();
        ext_clk1 = 1; step();
        chk("R2 capture with oe low", fb[0], 0);
    endtask

    task automatic t_clksel();
        // group A to pin2; both levels 1 -> 0 first to avoid an edge on switch
        ext_clk2 = 1; grp_clk_sel[1:0] = 2'b01; step();
        ext_clk2 = 0; step();
        pad_in[0] = 1; ext_clk1 = 0; step();
        ext_clk1 = 1; step();
        chk("R6 pin1 ignored when pin2 selected", fb[0], 0);
        ext_clk2 = 1; step();
        chk("R6 pin2 rise captures", fb[0], 1);
        arr_clk[0] = 1; grp_clk_sel[1:0] = 2'b10; step();
        pad_in[0] = 0; arr_clk[0] = 0; step();
        arr_clk[0] = 1; step();
        chk("R6 term rise captures", fb[0], 0);
        grp_clk_sel[1:0] = 2'b11; pad_in[0] = 1; arr_clk[0] = 0; step();
        arr_clk[0] = 1; step();
        chk("R6 code 11 selects term", fb[0], 1);
    endtask

    task automatic t_polarity();
        ext_clk1 = 0; grp_clk_inv[0] = 1; grp_clk_sel[1:0] = 2'b00; step();
        pad_in[0] = 0; ext_clk1 = 1; step();
        chk("R7 no capture on rise when inverted", fb[0], 1);
        ext_clk1 = 0; step();
        chk("R7 capture on fall when inverted", fb[0], 0);
    endtask

    task automatic t_groups();
        arr_clk[1] = 0; grp_clk_sel[3:2] = 2'b10; step(); step();
        pad_in[3] = 0; arr_clk[1] = 1; step();
        chk("R8 group B term captures", fb[3], 0);
        pad_in[3] = 1; pad_in[0] = 1;
        ext_clk1 = 1; step();
        ext_clk1 = 0; step();
        chk("R8 group A captures", fb[0], 1);
        chk("R8 group B untouched by A clock", fb[3], 0);
        arr_clk[1] = 0; step();
        pad_in[0] = 0; arr_clk[1] = 1; step();
        chk("R8 group B captures own term", fb[3], 1);
        chk("R8 group A untouched by B term", fb[0], 1);
    endtask

    initial begin
        t_reset();
        t_register();
        t_latch();
        t_bypass();
        t_output();
        t_clksel();
        t_polarity();
        t_groups();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule